// File: doc/BRIEF.md
# PHY Discovery and Link Bring-Up Sequencer

This block finds an Ethernet PHY on a clause-22 management bus and brings its link up without software help. A single start pulse launches the sequence. The block reads the two identifier registers at each address in turn until one address gives a plausible pair. It then resets that PHY and polls until the reset has cleared. Next it reads the detected speed and duplex, derives an advertisement word from the PHY's capability bits, and restarts auto-negotiation. Last, it polls until negotiation completes, a timeout is reached or a fault ends the attempt.

A small bit-serial engine inside the block generates the management clock, the data and the output-enable. The sequencer hands it one read or write at a time and waits for it to finish before issuing the next. The pad that merges data and output-enable into a bidirectional pin sits outside the block. Waits between polls are counted in pulses of an external tick input. At the end the block raises done, with fail showing whether the bring-up succeeded, plus a speed bit and a duplex bit.

Top module: `phy_link_seq`

## Requirements
- R1: A read frame is 64 bit times: 32 ones, start bits 0 then 1, op bits 1 then 0, the 5-bit PHY address and the 5-bit register number (both MSB first), all with output-enable high. These are followed by one idle bit, 16 sampled data bits (MSB first) and one idle bit, all with output-enable low.
- R2: A write frame is 65 bit times. It carries the same header with op bits 0 then 1, then two bit times with output-enable low, then 16 driven data bits (MSB first), then one bit time with output-enable low.
- R3: Data and output-enable change only while the management clock is low. Input is sampled late in the clock-high phase. Between frames the clock, the data and the output-enable are all low.
- R4: Addresses are scanned from 0 upward. At each address register 2 is read, then register 3. The first address where neither ID is 0x0000, 0xFFFF or 0x8000 is kept, and every later transaction goes to it.
- R5: If no address out of 32 qualifies, the block raises done and fail and issues no write.
- R6: The block writes 0x8000 (bit 15) to register 0, then reads register 0 until bit 15 is 0. It makes at most RST_POLLS reads (6 by default). If the bit is still set after the last read, the block finishes with fail.
- R7: The advertisement written to register 4 is 0x0001 plus status bits 15, 14, 13, 12 and 11 of register 1, copied to bits 9, 8, 7, 6 and 5.
- R8: After the advertisement the block writes 0x1200 to register 0. It then reads register 1 until bit 5 (negotiation complete) is set, making at most AN_POLLS reads (20 by default). Completion without fault ends with done and without fail.
- R9: If an incomplete poll shows bit 4 (remote fault), the block waits one poll interval and then writes 0x3300 to register 0 before the next poll. If bit 4 is set on the completing read, or all polls are used up, the block finishes with fail.
- R10: Register 18 is read once, right after the reset clears. The speed output takes its bit 7 and the duplex output its bit 6, and both hold until the next start.
- R11: Each retried poll is issued POLL_TICKS tick pulses after the previous poll ends, and only one management transaction is in flight at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that starts a bring-up when idle or finished |
| tick_i | input | 1 | Poll interval time base, one pulse per unit |
| mdio_i | input | 1 | Management data from the pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data toward the pad |
| mdio_oe_o | output | 1 | Output-enable for the data pad |
| done_o | output | 1 | Sequence finished (level, until next start) |
| fail_o | output | 1 | Sequence finished without a usable link |
| speed_o | output | 1 | Detected 100 Mb/s |
| duplex_o | output | 1 | Detected full duplex |

## Verification
The bench builds the block with HALF_CYC = 2 and POLL_TICKS = 3, and sends a tick every fourth clock. One frame then lasts about 260 cycles and a poll interval about a dozen. This keeps within easy reach a full 32-address scan that fails, a reset that holds through all six polls, and a negotiation that runs through all twenty polls. The bench PHY model decodes every frame bit by bit and answers reads with scripted values. Decoy addresses break the ID rule in each of its ways, and the model can also inject remote faults or withhold completion.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int DW     = 16;
  localparam int HDR_W  = 36 + PHY_AW + REG_AW;   // preamble, start, op, addresses
  localparam int FW     = HDR_W + DW + 3;          // longest (write) frame

  localparam logic [REG_AW-1:0] REG_CTRL = 5'd0;
  localparam logic [REG_AW-1:0] REG_STAT = 5'd1;
  localparam logic [REG_AW-1:0] REG_ID1  = 5'd2;
  localparam logic [REG_AW-1:0] REG_ID2  = 5'd3;
  localparam logic [REG_AW-1:0] REG_ADV  = 5'd4;
  localparam logic [REG_AW-1:0] REG_MODE = 5'd18;

  localparam int CTRL_RST  = 15;
  localparam int CTRL_SPD  = 13;
  localparam int CTRL_ANEN = 12;
  localparam int CTRL_ANRS = 9;
  localparam int CTRL_DPX  = 8;
  localparam int STAT_CMPL = 5;
  localparam int STAT_RFLT = 4;
  localparam int MODE_SPD  = 7;
  localparam int MODE_DPX  = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_ID1, S_ID2, S_RST_WR, S_RST_RD, S_RST_WAIT, S_MODE_RD,
    S_CAP_RD, S_ADV_WR, S_AN_WR, S_AN_RD, S_AN_WAIT, S_FLT_WR, S_END
  } seq_st_e;

  function automatic logic one_id_ok(input logic [DW-1:0] v);
    return (v != '0) && (v != '1) && (v != 16'h8000);
  endfunction

  function automatic logic [DW-1:0] adv_word(input logic [DW-1:0] stat);
    logic [DW-1:0] a;
    a      = 16'h0001;
    a[9:5] = stat[15:11];
    return a;
  endfunction
endpackage

// File: rtl/mgmt_bit_engine.sv
module mgmt_bit_engine
  import phy_seq_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [PHY_AW-1:0] phy_i,
  input  logic [REG_AW-1:0] reg_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              mdi_i,
  output logic              done_o,
  output logic              busy_o,
  output logic [DW-1:0]     rdata_o,
  output logic              mdc_o,
  output logic              mdo_o,
  output logic              oe_o
);
  localparam int HCW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BCW = $clog2(FW);

  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} eng_st_e;

  eng_st_e         st_q;
  logic [FW-1:0]   dat_q, oe_q, dat_d, oe_d;
  logic [DW-1:0]   cap_q;
  logic [BCW-1:0]  left_q;
  logic [HCW-1:0]  hc_q;
  logic [HDR_W-1:0] hdr;
  logic            half_end;

  assign hdr   = {32'hFFFF_FFFF, 2'b01, (wr_i ? 2'b01 : 2'b10), phy_i, reg_i};
  assign dat_d = wr_i ? {hdr, 2'b00, wdata_i, 1'b0} : {hdr, {(DW+3){1'b0}}};
  assign oe_d  = wr_i ? {{HDR_W{1'b1}}, 2'b00, {DW{1'b1}}, 1'b0}
                      : {{HDR_W{1'b1}}, {(DW+3){1'b0}}};
  assign half_end = (hc_q == HCW'(HALF_CYC-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= E_IDLE;
      dat_q   <= '0;
      oe_q    <= '0;
      cap_q   <= '0;
      left_q  <= '0;
      hc_q    <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        E_IDLE: if (req_i) begin
          dat_q  <= dat_d;
          oe_q   <= oe_d;
          left_q <= wr_i ? BCW'(FW-1) : BCW'(FW-2);
          hc_q   <= '0;
          st_q   <= E_LOW;
        end
        E_LOW: begin
          hc_q <= half_end ? '0 : hc_q + 1'b1;
          if (half_end) st_q <= E_HIGH;
        end
        default: begin
          hc_q <= half_end ? '0 : hc_q + 1'b1;
          if (half_end) begin
            cap_q <= {cap_q[DW-2:0], mdi_i};   // sample at end of high phase
            if (left_q == '0) begin
              st_q    <= E_IDLE;
              done_o  <= 1'b1;
              rdata_o <= cap_q;                // drops the final idle bit
            end else begin
              left_q <= left_q - 1'b1;
              dat_q  <= dat_q << 1;
              oe_q   <= oe_q << 1;
              st_q   <= E_LOW;
            end
          end
        end
      endcase
    end
  end

  assign busy_o = (st_q != E_IDLE);
  assign mdc_o  = (st_q == E_HIGH);
  assign mdo_o  = busy_o & dat_q[FW-1];
  assign oe_o   = busy_o & oe_q[FW-1];
endmodule

// File: rtl/poll_tick_timer.sv
module poll_tick_timer #(
  parameter int POLL_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = (POLL_TICKS > 1) ? $clog2(POLL_TICKS) : 1;

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (arm_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q && tick_i) begin
        if (cnt_q == CW'(POLL_TICKS-1)) begin
          run_q    <= 1'b0;
          expire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_seq_pkg::*;
#(
  parameter int HALF_CYC   = 25,
  parameter int POLL_TICKS = 500,
  parameter int RST_POLLS  = 6,
  parameter int AN_POLLS   = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  input  logic mdio_i,
  output logic mdc_o,
  output logic mdio_o,
  output logic mdio_oe_o,
  output logic done_o,
  output logic fail_o,
  output logic speed_o,
  output logic duplex_o
);
  localparam int PMAX = (RST_POLLS > AN_POLLS) ? RST_POLLS : AN_POLLS;
  localparam int PCW  = $clog2(PMAX + 1);

  seq_st_e           st_q;
  logic              pend_q, arm_q, flt_q;
  logic [PHY_AW-1:0] scan_q;
  logic [PCW-1:0]    poll_q;
  logic [DW-1:0]     id1_q, adv_q;
  logic              xact, x_wr, eng_req, eng_done, eng_busy, expire;
  logic [REG_AW-1:0] x_reg;
  logic [DW-1:0]     x_data, eng_rdata;

  always_comb begin
    xact   = 1'b1;
    x_wr   = 1'b0;
    x_reg  = REG_CTRL;
    x_data = '0;
    unique case (st_q)
      S_ID1:     x_reg = REG_ID1;
      S_ID2:     x_reg = REG_ID2;
      S_RST_WR:  begin x_wr = 1'b1; x_data[CTRL_RST] = 1'b1; end
      S_RST_RD:  x_reg = REG_CTRL;
      S_MODE_RD: x_reg = REG_MODE;
      S_CAP_RD,
      S_AN_RD:   x_reg = REG_STAT;
      S_ADV_WR:  begin x_wr = 1'b1; x_reg = REG_ADV; x_data = adv_q; end
      S_AN_WR:   begin
        x_wr = 1'b1; x_data[CTRL_ANEN] = 1'b1; x_data[CTRL_ANRS] = 1'b1;
      end
      S_FLT_WR:  begin
        x_wr = 1'b1; x_data[CTRL_ANEN] = 1'b1; x_data[CTRL_ANRS] = 1'b1;
        x_data[CTRL_SPD] = 1'b1; x_data[CTRL_DPX] = 1'b1;
      end
      default:   xact = 1'b0;
    endcase
  end

  assign eng_req = xact && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      pend_q   <= 1'b0;
      arm_q    <= 1'b0;
      flt_q    <= 1'b0;
      scan_q   <= '0;
      poll_q   <= '0;
      id1_q    <= '0;
      adv_q    <= '0;
      done_o   <= 1'b0;
      fail_o   <= 1'b0;
      speed_o  <= 1'b0;
      duplex_o <= 1'b0;
    end else begin
      arm_q <= 1'b0;
      if (eng_req)  pend_q <= 1'b1;
      if (eng_done) pend_q <= 1'b0;
      unique case (st_q)
        S_ID1: if (eng_done) begin
          id1_q <= eng_rdata;
          st_q  <= S_ID2;
        end
        S_ID2: if (eng_done) begin
          if (one_id_ok(id1_q) && one_id_ok(eng_rdata)) st_q <= S_RST_WR;
          else if (scan_q == '1) begin
            st_q <= S_END; done_o <= 1'b1; fail_o <= 1'b1;
          end else begin
            scan_q <= scan_q + 1'b1;
            st_q   <= S_ID1;
          end
        end
        S_RST_WR: if (eng_done) begin
          poll_q <= '0;
          st_q   <= S_RST_RD;
        end
        S_RST_RD: if (eng_done) begin
          if (!eng_rdata[CTRL_RST]) st_q <= S_MODE_RD;
          else if (poll_q == PCW'(RST_POLLS-1)) begin
            st_q <= S_END; done_o <= 1'b1; fail_o <= 1'b1;
          end else begin
            poll_q <= poll_q + 1'b1;
            arm_q  <= 1'b1;
            st_q   <= S_RST_WAIT;
          end
        end
        S_RST_WAIT: if (expire) st_q <= S_RST_RD;
        S_MODE_RD: if (eng_done) begin
          speed_o  <= eng_rdata[MODE_SPD];
          duplex_o <= eng_rdata[MODE_DPX];
          st_q     <= S_CAP_RD;
        end
        S_CAP_RD: if (eng_done) begin
          adv_q <= adv_word(eng_rdata);
          st_q  <= S_ADV_WR;
        end
        S_ADV_WR: if (eng_done) st_q <= S_AN_WR;
        S_AN_WR: if (eng_done) begin
          poll_q <= '0;
          st_q   <= S_AN_RD;
        end
        S_AN_RD: if (eng_done) begin
          flt_q <= eng_rdata[STAT_RFLT];
          if (eng_rdata[STAT_CMPL]) begin
            st_q <= S_END; done_o <= 1'b1; fail_o <= eng_rdata[STAT_RFLT];
          end else if (poll_q == PCW'(AN_POLLS-1)) begin
            st_q <= S_END; done_o <= 1'b1; fail_o <= 1'b1;
          end else begin
            poll_q <= poll_q + 1'b1;
            arm_q  <= 1'b1;
            st_q   <= S_AN_WAIT;
          end
        end
        S_AN_WAIT: if (expire) st_q <= flt_q ? S_FLT_WR : S_AN_RD;
        S_FLT_WR: if (eng_done) st_q <= S_AN_RD;
        default: if (start_i) begin   // S_IDLE, S_END
          st_q     <= S_ID1;
          scan_q   <= '0;
          done_o   <= 1'b0;
          fail_o   <= 1'b0;
          speed_o  <= 1'b0;
          duplex_o <= 1'b0;
        end
      endcase
    end
  end

  mgmt_bit_engine #(.HALF_CYC(HALF_CYC)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (eng_req),
    .wr_i    (x_wr),
    .phy_i   (scan_q),
    .reg_i   (x_reg),
    .wdata_i (x_data),
    .mdi_i   (mdio_i),
    .done_o  (eng_done),
    .busy_o  (eng_busy),
    .rdata_o (eng_rdata),
    .mdc_o   (mdc_o),
    .mdo_o   (mdio_o),
    .oe_o    (mdio_oe_o)
  );

  poll_tick_timer #(.POLL_TICKS(POLL_TICKS)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_q),
    .tick_i   (tick_i),
    .expire_o (expire)
  );
endmodule

// File: rtl/phy_link_seq_chk.sv
module phy_link_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o,
  input logic done_o,
  input logic fail_o,
  input logic speed_o,
  input logic duplex_o,
  input logic eng_req,
  input logic eng_busy
);
  assert_data_moves_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mdio_o) || !$stable(mdio_oe_o)) |-> !mdc_o);

  assert_bus_idle_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mdc_o && !mdio_o && !mdio_oe_o));

  assert_single_xact_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy |-> !eng_req);

  assert_fail_with_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);

  assert_mode_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> ($stable(speed_o) && $stable(duplex_o)));
endmodule

bind phy_link_seq phy_link_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .speed_o   (speed_o),
  .duplex_o  (duplex_o),
  .eng_req   (eng_req),
  .eng_busy  (eng_busy)
);

// File: tb/tb_phy_link_seq.sv
`timescale 1ns/1ps
module tb_phy_link_seq;
  localparam int POLL_T = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic tick_i = 1'b0;
  logic mdio_i;
  logic mdc_o, mdio_o, mdio_oe_o, done_o, fail_o, speed_o, duplex_o;

  int n_chk = 0;
  int n_bad = 0;
  int tick_cnt = 0;

  // PHY model configuration and observations
  int          m_addr, m_rst_busy, m_cmpl_at, m_flt_n;
  logic [15:0] m_caps, m_mode;
  int          n_id, n_ctrl, n_an, n_wr, scan_exp, scan_bad, addr_bad, fmt_err;
  int          gap_n, gap_bad, gap_mark;
  bit          gap_pend, an_started, rd_gap;
  logic [4:0]  wr_reg [0:7];
  logic [15:0] wr_dat [0:7];
  logic        f_bits [0:64];
  logic        f_oe   [0:64];
  int          f_idx = 0;
  bit          f_rd = 1'b0;
  logic [4:0]  f_pa, f_ra;
  logic [15:0] f_rval;

  always #4 clk = ~clk;   // 125 MHz

  phy_link_seq #(.HALF_CYC(2), .POLL_TICKS(POLL_T), .RST_POLLS(6), .AN_POLLS(20)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .tick_i(tick_i), .mdio_i(mdio_i),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .done_o(done_o),
    .fail_o(fail_o), .speed_o(speed_o), .duplex_o(duplex_o)
  );

  initial begin
    forever begin
      repeat (3) @(posedge clk);
      #1 tick_i = 1'b1; tick_cnt++;
      @(posedge clk);
      #1 tick_i = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic clr_model(input int addr, input int rbusy, input logic [15:0] caps,
                           input int cmpl, input int flt, input logic [15:0] mode);
    m_addr = addr; m_rst_busy = rbusy; m_caps = caps; m_cmpl_at = cmpl;
    m_flt_n = flt; m_mode = mode;
    n_id = 0; n_ctrl = 0; n_an = 0; n_wr = 0; scan_exp = 0; scan_bad = 0;
    addr_bad = 0; fmt_err = 0; gap_n = 0; gap_bad = 0; gap_pend = 0;
    an_started = 0;
    for (int i = 0; i < 8; i++) begin wr_reg[i] = '0; wr_dat[i] = '0; end
  endtask

  task automatic reply(output logic [15:0] v);
    int k;
    v = 16'hFFFF;
    rd_gap = 1'b0;
    if (f_ra == 5'd2 || f_ra == 5'd3) begin
      n_id++;
      if (f_ra == 5'd2) begin
        if (int'(f_pa) != scan_exp) scan_bad++;
        scan_exp = int'(f_pa) + 1;
      end
      if (int'(f_pa) == m_addr) v = (f_ra == 5'd2) ? 16'h0022 : 16'h1619;
      else if (f_pa == 5'd1) v = (f_ra == 5'd2) ? 16'h8000 : 16'h1234;
      else if (f_pa == 5'd2) v = (f_ra == 5'd2) ? 16'h0040 : 16'h0000;
      else if (f_pa == 5'd3) v = (f_ra == 5'd2) ? 16'h0040 : 16'h8000;
    end else begin
      if (int'(f_pa) != m_addr) addr_bad++;
      if (f_ra == 5'd0) begin
        v = (n_ctrl < m_rst_busy) ? 16'h8000 : 16'h0000;
        rd_gap = (n_ctrl < m_rst_busy);
        n_ctrl++;
      end else if (f_ra == 5'd18) begin
        v = m_mode;
      end else if (f_ra == 5'd1) begin
        v = m_caps | 16'h0009;
        if (an_started) begin
          n_an++;
          k = n_an;
          if (m_cmpl_at != 0 && k >= m_cmpl_at) v[5] = 1'b1;
          if (k <= m_flt_n) v[4] = 1'b1;
          rd_gap = !v[5];
        end
      end
    end
  endtask

  // PHY model: decodes frames at each rising management clock
  initial begin
    mdio_i = 1'b0;
    forever begin
      @(posedge mdc_o);
      if (f_idx == 0 && gap_pend) begin
        gap_n++;
        if (tick_cnt - gap_mark < POLL_T || tick_cnt - gap_mark > POLL_T + 2) gap_bad++;
        gap_pend = 1'b0;
      end
      f_bits[f_idx] = mdio_o;
      f_oe[f_idx]   = mdio_oe_o;
      mdio_i = 1'b0;
      if (f_idx == 45) begin
        for (int i = 0; i < 32; i++) if (!f_bits[i] || !f_oe[i]) fmt_err++;
        if (f_bits[32] || !f_bits[33]) fmt_err++;
        for (int i = 32; i < 46; i++) if (!f_oe[i]) fmt_err++;
        if (f_bits[34] && !f_bits[35]) f_rd = 1'b1;
        else if (!f_bits[34] && f_bits[35]) f_rd = 1'b0;
        else begin fmt_err++; f_rd = 1'b1; end
        f_pa = '0; f_ra = '0;
        for (int i = 0; i < 5; i++) begin
          f_pa = {f_pa[3:0], f_bits[36+i]};
          f_ra = {f_ra[3:0], f_bits[41+i]};
        end
        if (f_rd) reply(f_rval);
      end
      if (f_rd && f_idx >= 47 && f_idx <= 62) mdio_i = f_rval[62 - f_idx];
      f_idx++;
      if (f_rd && f_idx == 64) begin
        for (int i = 46; i < 64; i++) if (f_oe[i]) fmt_err++;
        if (rd_gap) begin gap_mark = tick_cnt; gap_pend = 1'b1; end
        f_idx = 0;
      end else if (!f_rd && f_idx == 65) begin
        logic [15:0] wd;
        if (f_oe[46] || f_oe[47] || f_oe[64]) fmt_err++;
        wd = '0;
        for (int i = 0; i < 16; i++) begin
          if (!f_oe[48+i]) fmt_err++;
          wd = {wd[14:0], f_bits[48+i]};
        end
        if (int'(f_pa) != m_addr) addr_bad++;
        if (n_wr < 8) begin wr_reg[n_wr] = f_ra; wr_dat[n_wr] = wd; end
        n_wr++;
        if (f_ra == 5'd0 && wd[12]) an_started = 1'b1;
        f_idx = 0;
      end
    end
  end

  task automatic run_seq;
    int guard;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 60000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R5 reset done", done_o, 0);
    check("R5 reset fail", fail_o, 0);
    check("R3 reset idle bus", {mdc_o, mdio_o, mdio_oe_o}, 0);
    check("R10 reset mode", {speed_o, duplex_o}, 0);
  endtask

  task automatic t_basic;
    clr_model(4, 5, 16'hF800, 3, 0, 16'h00C0);
    run_seq();
    check("R8 done", done_o, 1);
    check("R8 no fail", fail_o, 0);
    check("R1 R2 frame format", fmt_err, 0);
    check("R3 idle bus after done", {mdc_o, mdio_o, mdio_oe_o}, 0);
    check("R4 id reads", n_id, 10);
    check("R4 ascending scan", scan_bad, 0);
    check("R4 chosen address", addr_bad, 0);
    check("R6 reset write", wr_dat[0], 16'h8000);
    check("R6 reset polls", n_ctrl, 6);
    check("R7 adv all caps", wr_dat[1], 16'h03E1);
    check("R7 adv register", wr_reg[1], 4);
    check("R8 restart word", wr_dat[2], 16'h1200);
    check("R8 status polls", n_an, 3);
    check("R8 write count", n_wr, 3);
    check("R10 speed", speed_o, 1);
    check("R10 duplex", duplex_o, 1);
    check("R11 poll spacing", gap_bad, 0);
    check("R11 gaps seen", gap_n, 7);
  endtask

  task automatic t_no_phy;
    clr_model(40, 0, 16'hF800, 1, 0, 16'h00C0);
    run_seq();
    check("R5 done", done_o, 1);
    check("R5 fail", fail_o, 1);
    check("R5 full scan", n_id, 64);
    check("R4 ascending scan", scan_bad, 0);
    check("R5 no writes", n_wr, 0);
    check("R10 mode cleared", {speed_o, duplex_o}, 0);
  endtask

  task automatic t_rst_timeout;
    clr_model(4, 6, 16'hF800, 1, 0, 16'h00C0);
    run_seq();
    check("R6 fail", fail_o, 1);
    check("R6 done", done_o, 1);
    check("R6 poll limit", n_ctrl, 6);
    check("R6 only reset written", n_wr, 1);
    check("R11 poll spacing", gap_bad, 0);
    check("R10 mode not read", {speed_o, duplex_o}, 0);
  endtask

  task automatic t_fault_recover;
    clr_model(4, 0, 16'h6000, 3, 1, 16'h0080);
    run_seq();
    check("R9 done", done_o, 1);
    check("R9 no fail", fail_o, 0);
    check("R6 single reset read", n_ctrl, 1);
    check("R7 adv 100 caps", wr_dat[1], 16'h0181);
    check("R9 fault restart", wr_dat[3], 16'h3300);
    check("R9 write count", n_wr, 4);
    check("R9 status polls", n_an, 3);
    check("R10 speed", speed_o, 1);
    check("R10 duplex", duplex_o, 0);
    check("R1 R2 frame format", fmt_err, 0);
  endtask

  task automatic t_fault_final;
    clr_model(4, 0, 16'hF800, 1, 1, 16'h0000);
    run_seq();
    check("R9 fault on completion fails", fail_o, 1);
    check("R9 one poll", n_an, 1);
    check("R9 no restart write", n_wr, 3);
  endtask

  task automatic t_aneg_timeout;
    clr_model(4, 0, 16'h1800, 0, 0, 16'h0040);
    run_seq();
    check("R9 exhausted fails", fail_o, 1);
    check("R8 poll limit", n_an, 20);
    check("R7 adv 10 caps", wr_dat[1], 16'h0061);
    check("R10 speed", speed_o, 0);
    check("R10 duplex", duplex_o, 1);
    check("R11 poll spacing", gap_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_no_phy();
    t_rst_timeout();
    t_fault_recover();
    t_fault_final();
    t_aneg_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule